// File: doc/BRIEF.md
# Pixel Clock Program Word Encoder

This block turns a requested pixel clock period, given in picoseconds, into the 13-bit program word that a serially loaded clock synthesizer expects. First it converts the period into a frequency counted in units of 0.01 MHz. It then rejects frequencies outside the synthesizer's range. If the frequency is low, it scales it into the synthesizer's operating band by doubling, and counts the doublings as a post-divider. Finally it derives a rounded feedback count from the scaled frequency and merges that count with a divider code and fixed stop bits.

All three integer divisions run one after another on a single shared restoring divider, which produces one quotient bit per clock. A conversion therefore takes roughly a hundred cycles. The block accepts one request at a time. The result is reported by a one-cycle done pulse, which comes with either a valid pulse or an error pulse. The word and the post-divider stay on the outputs until the next successful conversion.

Top module: `pclk_word_enc`

## Requirements
- R1: The working frequency f is the integer quotient floor(100000000 / period_ps), expressed in 0.01 MHz units.
- R2: A frequency f greater than 15938 ends the conversion with error high and valid low. word and post_div keep their previous values.
- R3: A frequency f below 1000 is rejected in the same way, and so is a period of 0.
- R4: Starting with post_div = 1, while f < 8000 the block doubles both f and post_div. post_div is therefore 1, 2, 4 or 8, which is one-hot on the 4-bit port.
- R5: The feedback count is fb = floor((floor(46 * f * 1000 / 1432) + 500) / 1000), where f is the scaled frequency.
- R6: word[8:0] = fb - 257 and word[12:11] = 2'b11 (stop bits). word[10:9] is the divider code: 2'b11 for ÷1, 2'b10 for ÷2, 2'b01 for ÷4 and 2'b00 for ÷8.
- R7: A start pulse that arrives while a conversion is in progress is ignored. It produces no result of its own and does not change the running result.
- R8: done is a one-cycle pulse. In the cycle it is high, exactly one of valid and error is high. Neither valid nor error is ever high without done.
- R9: After a synchronous reset, done, valid and error are low, and word and post_div are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion of period_ps (sampled when idle) |
| period_ps | input | 32 | Requested pixel clock period in picoseconds |
| done | output | 1 | One-cycle pulse when a conversion ends |
| valid | output | 1 | Result accepted; word and post_div updated |
| error | output | 1 | Request rejected as out of range |
| word | output | 13 | Program word: stop bits, divider code, program field |
| post_div | output | 4 | Chosen post-divider (1, 2, 4 or 8) |

## Verification
The hardest case to reach is a second start request that lands while the shared divider is in the middle of an earlier conversion. The stimulus pulses start a few cycles after an accepted request, using a period that would give a different word. The scoreboard then holds exactly one expected item, so any extra result or any corruption of the word shows up as a mismatch. The range edges are reached with periods one picosecond apart, chosen so that the truncating first division lands exactly on or just past each limit. The doubling boundary is reached the same way: one period gives exactly 8000, and the next gives 7999, which forces a single doubling.

// File: rtl/pclk_word_pkg.sv
package pclk_word_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_CHECK,
    ST_DBL,
    ST_FB1,
    ST_FB2
  } enc_state_t;

  // Two-bit divider code placed next to the program field.
  function automatic logic [1:0] pd_code(input logic [3:0] pd);
    case (pd)
      4'd1:    pd_code = 2'b11;
      4'd2:    pd_code = 2'b10;
      4'd4:    pd_code = 2'b01;
      default: pd_code = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/pclk_restoring_div.sv
module pclk_restoring_div #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W-1:0]  acc;
  logic [W-1:0]  q;
  logic [W-1:0]  dsr;
  logic [W-1:0]  dvd;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic [W-1:0]  acc_nxt;
  logic [W-1:0]  q_nxt;

  always_comb begin
    shifted = {acc, q[W-1]};
    diff    = shifted - {1'b0, dsr};
    if (!diff[W]) begin
      acc_nxt = diff[W-1:0];
      q_nxt   = {q[W-2:0], 1'b1};
    end else begin
      acc_nxt = shifted[W-1:0];
      q_nxt   = {q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      q    <= '0;
      dsr  <= '0;
      dvd  <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
        acc  <= '0;
        q    <= dividend;
        dsr  <= divisor;
        dvd  <= dividend;
      end else if (busy) begin
        acc <= acc_nxt;
        q   <= q_nxt;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign quotient = q;

  // Quotient and remainder reconstruct the dividend when a division ends (R1, R5).
  assert_div_exact_R5: assert property (@(posedge clk) disable iff (rst)
    (done && dsr != '0) |->
      ((({W'(0), q} * {W'(0), dsr}) + {W'(0), acc}) == {W'(0), dvd}) && (acc < dsr));

  assert_div_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/pclk_word_pack.sv
module pclk_word_pack
  import pclk_word_pkg::*;
#(
  parameter int DW = 32,
  parameter int PROG_W = 9,
  parameter int unsigned FB_ADJ = 257,
  localparam int WORD_W = PROG_W + 4
) (
  input  logic [DW-1:0]     fb,
  input  logic [3:0]        pd,
  output logic [WORD_W-1:0] word
);

  logic [DW-1:0] prog_full;

  always_comb begin
    prog_full = fb - DW'(FB_ADJ);
    word      = {2'b11, pd_code(pd), prog_full[PROG_W-1:0]};
  end

endmodule

// File: rtl/pclk_word_enc.sv
module pclk_word_enc
  import pclk_word_pkg::*;
#(
  parameter int DW = 32,
  parameter int PROG_W = 9,
  parameter int unsigned REF_NUM = 100000000,
  parameter int unsigned MAX_F = 15938,
  parameter int unsigned MIN_F = 1000,
  parameter int unsigned DBL_F = 8000,
  parameter int unsigned FB_MULT = 46,
  parameter int unsigned FB_REF = 1432,
  parameter int unsigned FB_SCALE = 1000,
  parameter int unsigned FB_ADJ = 257,
  localparam int WORD_W = PROG_W + 4,
  localparam int PD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DW-1:0]     period_ps,
  output logic              done,
  output logic              valid,
  output logic              error,
  output logic [WORD_W-1:0] word,
  output logic [PD_W-1:0]   post_div
);

  enc_state_t           st_q;
  logic [DW-1:0]        freq_q;
  logic [PD_W-1:0]      pd_q;
  logic                 div_go;
  logic [DW-1:0]        div_a;
  logic [DW-1:0]        div_b;
  logic                 div_done;
  logic [DW-1:0]        div_q;
  logic [WORD_W-1:0]    packed_word;

  pclk_restoring_div #(.W(DW)) div_i (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .done     (div_done),
    .quotient (div_q)
  );

  pclk_word_pack #(.DW(DW), .PROG_W(PROG_W), .FB_ADJ(FB_ADJ)) pack_i (
    .fb   (div_q),
    .pd   (pd_q),
    .word (packed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      freq_q   <= '0;
      pd_q     <= '0;
      div_go   <= 1'b0;
      div_a    <= '0;
      div_b    <= '0;
      done     <= 1'b0;
      valid    <= 1'b0;
      error    <= 1'b0;
      word     <= '0;
      post_div <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      valid  <= 1'b0;
      error  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (period_ps == '0) begin
              done  <= 1'b1;
              error <= 1'b1;
            end else begin
              div_a  <= DW'(REF_NUM);
              div_b  <= period_ps;
              div_go <= 1'b1;
              st_q   <= ST_FREQ;
            end
          end
        end
        ST_FREQ: begin
          if (div_done) begin
            freq_q <= div_q;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (freq_q > DW'(MAX_F) || freq_q < DW'(MIN_F)) begin
            done  <= 1'b1;
            error <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            pd_q <= PD_W'(1);
            st_q <= ST_DBL;
          end
        end
        ST_DBL: begin
          if (freq_q < DW'(DBL_F)) begin
            freq_q <= freq_q << 1;
            pd_q   <= pd_q << 1;
          end else begin
            div_a  <= freq_q * DW'(FB_MULT * FB_SCALE);
            div_b  <= DW'(FB_REF);
            div_go <= 1'b1;
            st_q   <= ST_FB1;
          end
        end
        ST_FB1: begin
          if (div_done) begin
            div_a  <= div_q + DW'(FB_SCALE / 2);
            div_b  <= DW'(FB_SCALE);
            div_go <= 1'b1;
            st_q   <= ST_FB2;
          end
        end
        ST_FB2: begin
          if (div_done) begin
            word     <= packed_word;
            post_div <= pd_q;
            done     <= 1'b1;
            valid    <= 1'b1;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(valid && error));

  assert_done_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (valid || error) |-> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_pd_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($countones(post_div) == 1));

  assert_stop_bits_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> (word[WORD_W-1 -: 2] == 2'b11));

  assert_err_hold_R2: assert property (@(posedge clk) disable iff (rst)
    error |-> ($stable(word) && $stable(post_div)));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && start) |=> (st_q != ST_IDLE || $past(done)));

endmodule

// File: tb/pclk_word_enc_tb.sv
module pclk_word_enc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] period_ps = '0;
  logic        done, valid, error;
  logic [12:0] word;
  logic [3:0]  post_div;

  always #2 clk = ~clk;

  pclk_word_enc dut_i (
    .clk(clk), .rst(rst), .start(start), .period_ps(period_ps),
    .done(done), .valid(valid), .error(error), .word(word), .post_div(post_div)
  );

  typedef struct {
    logic        err;
    logic [12:0] w;
    logic [3:0]  pd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic [12:0] last_w = '0;
  logic [3:0]  last_pd = '0;
  logic prev_done = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference model built from the requirements.
  function automatic exp_t model(input longint p, input string tag);
    exp_t e;
    longint f, pd, fb, prog;
    logic [1:0] code;
    e.tag = tag;
    if (p == 0) begin e.err = 1; e.w = last_w; e.pd = last_pd; return e; end
    f = 100000000 / p;
    if (f > 15938 || f < 1000) begin e.err = 1; e.w = last_w; e.pd = last_pd; return e; end
    pd = 1;
    while (f < 8000) begin f = f * 2; pd = pd * 2; end
    fb = ((46 * f * 1000) / 1432 + 500) / 1000;
    prog = fb - 257;
    code = (pd == 1) ? 2'b11 : (pd == 2) ? 2'b10 : (pd == 4) ? 2'b01 : 2'b00;
    e.err = 0;
    e.w = {2'b11, code, prog[8:0]};
    e.pd = pd[3:0];
    last_w = e.w;
    last_pd = e.pd;
    return e;
  endfunction

  task automatic drive(input longint p, input string tag);
    exp_q.push_back(model(p, tag));
    @(negedge clk);
    start = 1'b1;
    period_ps = p[31:0];
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) chk(!done, "R8 done width", done, 0);
      if (done) begin
        chk(valid ^ error, "R8 valid xor error", {valid, error}, 1);
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected result", word, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(error == e.err, {e.tag, " error"}, error, e.err);
          chk(word == e.w, {e.tag, " word"}, word, e.w);
          chk(post_div == e.pd, {e.tag, " post_div"}, post_div, e.pd);
        end
      end else begin
        if (valid || error) chk(0, "R8 flag without done", {valid, error}, 0);
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!done && !valid && !error, "R9 reset flags", {done, valid, error}, 0);
    chk(word == 0 && post_div == 0, "R9 reset outputs", {word, post_div}, 0);
    rst = 1'b0;
    @(negedge clk);
    drive(10000,  "R6 div1 mid");
    drive(12500,  "R4 exact 8000 no doubling");
    drive(12501,  "R1 truncation 7999 doubles");
    drive(20000,  "R4 div2");
    drive(40000,  "R4 div4");
    drive(100000, "R3 lower edge div8");
    drive(100001, "R3 just below 1000");
    drive(6274,   "R2 upper edge accepted");
    drive(6273,   "R2 just above 15938");
    drive(0,      "R3 zero period");
    drive(7000,   "R5 rounding");
    // R7: second start during a running conversion
    exp_q.push_back(model(25000, "R7 first request kept"));
    @(negedge clk); start = 1'b1; period_ps = 25000;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; period_ps = 50000;
    @(negedge clk); start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (150) @(negedge clk);
    drive(33000, "R6 div4 after ignore");
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule